// File: doc/BRIEF.md
# Pin Bank with Edge-Capture Interrupt

This block is a bank of general-purpose pins behind a small 32-bit register port. Software sets each pin's direction and the value it drives, and reads back the pin levels. Each input passes through a two-stage synchronizer. A per-pin enable decides which pins may raise the single interrupt line.

The interrupt trigger is chosen when the block is built, from four options: rising edge, falling edge, either edge, or level high. In the three edge modes, detected edges are held in a sticky capture register. The interrupt stays asserted while any held, enabled bit remains. Software clears a held bit by writing a one to it. In level mode nothing is held, and the interrupt follows the enabled pin levels directly.

The pad is modelled as three vectors: a drive value, a drive enable and a sampled input. Pin vectors are always 32 bits wide. Only the lower, configured part of each vector is live.

Top module: `pio_edge_bank`

## Requirements
- R1: Register word select is `busAddr[3:2]`: 0 pin data, 1 direction, 2 interrupt enable, 3 edge capture. An access whose `busAddr[1:0]` is nonzero is ignored: a write changes nothing and a read returns zero. Read data appears on `busRdata` one clock after `busRe`, and holds while `busRe` is low.
- R2: The live pin count is `PIN_REQ` clamped to at most 32 (default 32). Bits at or above it read as zero, ignore writes, and drive 0 on `pinOut` and `pinOe`.
- R3: `pinOe` equals the direction register, where a 1 makes the pin an output. `pinOut` equals the data register. Both take a written value one clock after the write.
- R4: A pin data read returns, per bit, the written value when the direction bit is 1, and the synchronized `pinIn` when it is 0.
- R5: After reset, every register reads zero and `irq` is low. Every pin is therefore an input with its interrupt disabled.
- R6: An interrupt-enable bit of 1 lets that pin raise `irq`. A bit of 0 blocks it. An all-zero enable write forces `irq` low on the next cycle.
- R7: In an edge mode, a `pinIn` transition of the built type (0→1 for rising, 1→0 for falling, either for both) sets the matching capture bit. The bit is set three clocks after the change, whatever the enable and direction bits are.
- R8: In an edge mode, `irq` is high exactly when the capture register ANDed with the enable register is nonzero.
- R9: Writing offset 0xC clears each capture bit whose write-data bit is 1. Bits written 0 are unchanged.
- R10: If an edge sets a capture bit in the same clock as a clearing write to that bit, the bit stays set.
- R11: In level mode, `irq` is the OR of (pin data as in R4 AND enable), and the capture register always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Byte address of the register |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| pinIn | input | 32 | Sampled pad levels |
| pinOut | output | 32 | Values driven to pads |
| pinOe | output | 32 | Pad drive enables |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds four copies side by side and drives them all with the same bus and pin stimulus:
- A 40-pin request in either-edge mode, which exercises the clamp to 32.
- A 12-pin rising-edge bank.
- A 20-pin falling-edge bank.
- An 8-pin level-mode bank.

Because the stimulus is shared, one edge lands in some banks and not in others, and the upper-bit masking is checked at three different widths. The narrow widths leave dead bits, so writes and pin changes reach bits that must stay zero.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PIO_MAX = 32;
  localparam int PIO_ADDR_W = 4;

  typedef enum logic [1:0] {TRIG_RISE, TRIG_FALL, TRIG_BOTH, TRIG_LEVEL} trig_e;
  typedef enum logic [1:0] {SEL_DATA, SEL_DIR, SEL_MASK, SEL_CAP} sel_e;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrMask;
    logic wrCap;
    logic rdEn;
    logic rdHit;
    sel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic [PIO_ADDR_W-1:0] busAddr,
  input  logic                  busWe,
  input  logic                  busRe,
  output strobe_t               strb
);
  logic aligned;
  sel_e sel;

  always_comb begin
    aligned     = (busAddr[1:0] == 2'b00);
    sel         = sel_e'(busAddr[3:2]);
    strb.wrData = busWe && aligned && (sel == SEL_DATA);
    strb.wrDir  = busWe && aligned && (sel == SEL_DIR);
    strb.wrMask = busWe && aligned && (sel == SEL_MASK);
    strb.wrCap  = busWe && aligned && (sel == SEL_CAP);
    strb.rdEn   = busRe;
    strb.rdHit  = aligned;
    strb.rdSel  = sel;
  end
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int    NPIN = 32,
  parameter trig_e TRIG = TRIG_BOTH
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [PIO_MAX-1:0] wdata,
  input  logic [PIO_MAX-1:0] pinIn,
  output logic [PIO_MAX-1:0] rdata,
  output logic [PIO_MAX-1:0] pinOut,
  output logic [PIO_MAX-1:0] pinOe,
  output logic               irq
);
  localparam logic [PIO_MAX-1:0] LIVE = PIO_MAX'((64'd1 << NPIN) - 64'd1);
  localparam bit IS_LEVEL = (TRIG == TRIG_LEVEL);

  logic [PIO_MAX-1:0] outReg, dirReg, maskReg, capReg;
  logic [PIO_MAX-1:0] syncA, syncB;
  logic [PIO_MAX-1:0] edgeEvt, level, wLive, rdMux;

  assign wLive = wdata & LIVE;

  // two-stage input synchronizer, dead bits held at zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn & LIVE;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg  <= '0;
      dirReg  <= '0;
      maskReg <= '0;
    end else begin
      if (strb.wrData) outReg  <= wLive;
      if (strb.wrDir)  dirReg  <= wLive;
      if (strb.wrMask) maskReg <= wLive;
    end
  end

  assign level = (dirReg & outReg) | (~dirReg & syncB);

  generate
    if (IS_LEVEL) begin : g_level
      assign edgeEvt = '0;
      assign capReg  = '0;
      assign irq     = |(level & maskReg);
    end else begin : g_edge
      logic [PIO_MAX-1:0] prevB, clrBits;
      if (TRIG == TRIG_RISE) begin : g_rise
        assign edgeEvt = syncB & ~prevB;
      end else if (TRIG == TRIG_FALL) begin : g_fall
        assign edgeEvt = ~syncB & prevB;
      end else begin : g_both
        assign edgeEvt = syncB ^ prevB;
      end
      assign clrBits = strb.wrCap ? wLive : '0;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prevB  <= '0;
          capReg <= '0;
        end else begin
          prevB  <= syncB;
          // new edge wins over a same-cycle clear
          capReg <= (capReg & ~clrBits) | edgeEvt;
        end
      end
      assign irq = |(capReg & maskReg);
    end
  endgenerate

  always_comb begin
    unique case (strb.rdSel)
      SEL_DATA: rdMux = level;
      SEL_DIR:  rdMux = dirReg;
      SEL_MASK: rdMux = maskReg;
      default:  rdMux = capReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdata <= '0;
    else if (strb.rdEn) rdata <= strb.rdHit ? rdMux : '0;
  end

  assign pinOut = outReg;
  assign pinOe  = dirReg;
endmodule

// File: rtl/pio_edge_bank.sv
module pio_edge_bank
  import pio_pkg::*;
#(
  parameter int    PIN_REQ = 32,
  parameter trig_e TRIG    = TRIG_BOTH
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PIO_ADDR_W-1:0] busAddr,
  input  logic                  busWe,
  input  logic [PIO_MAX-1:0]    busWdata,
  input  logic                  busRe,
  output logic [PIO_MAX-1:0]    busRdata,
  input  logic [PIO_MAX-1:0]    pinIn,
  output logic [PIO_MAX-1:0]    pinOut,
  output logic [PIO_MAX-1:0]    pinOe,
  output logic                  irq
);
  localparam int NPIN = (PIN_REQ > PIO_MAX) ? PIO_MAX : PIN_REQ;

  strobe_t strb;

  pio_ctrl ctrl_i (
    .busAddr(busAddr),
    .busWe  (busWe),
    .busRe  (busRe),
    .strb   (strb)
  );

  pio_datapath #(.NPIN(NPIN), .TRIG(TRIG)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wdata (busWdata),
    .pinIn (pinIn),
    .rdata (busRdata),
    .pinOut(pinOut),
    .pinOe (pinOe),
    .irq   (irq)
  );
endmodule

// File: rtl/pio_edge_bank_chk.sv
module pio_edge_bank_chk
  import pio_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [PIO_ADDR_W-1:0] busAddr,
  input logic                  busWe,
  input logic [PIO_MAX-1:0]    busWdata,
  input logic                  busRe,
  input logic [PIO_MAX-1:0]    busRdata,
  input logic [PIO_MAX-1:0]    pinOut,
  input logic [PIO_MAX-1:0]    pinOe,
  input logic                  irq
);
  localparam logic [PIO_MAX-1:0] LIVE = PIO_MAX'((64'd1 << NPIN) - 64'd1);

  a_r5_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (pinOe == '0 && pinOut == '0 && !irq));

  a_r2_dead_bits: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOut | pinOe) & ~LIVE) == '0);

  a_r3_oe_follows: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 4'h4) |=> (pinOe == ($past(busWdata) & LIVE)));

  a_r3_out_follows: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 4'h0) |=> (pinOut == ($past(busWdata) & LIVE)));

  a_r1_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> $stable(busRdata));

  a_r6_mask_off: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 4'h8 && busWdata == '0) |=> !irq);
endmodule

bind pio_edge_bank pio_edge_bank_chk #(.NPIN(NPIN)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWe   (busWe),
  .busWdata(busWdata),
  .busRe   (busRe),
  .busRdata(busRdata),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .irq     (irq)
);

// File: tb/pio_edge_bank_tb_top.sv
`timescale 1ns/1ps
module pio_edge_bank_tb_top;
  import pio_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] pinIn = '0;
  logic [31:0] rdata [4];
  logic [31:0] pOut [4];
  logic [31:0] pOe [4];
  logic        irqV [4];

  always #2.5 clk = ~clk;

  pio_edge_bank #(.PIN_REQ(40), .TRIG(TRIG_BOTH)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRe(busRe), .busRdata(rdata[0]), .pinIn(pinIn), .pinOut(pOut[0]),
    .pinOe(pOe[0]), .irq(irqV[0]));
  pio_edge_bank #(.PIN_REQ(12), .TRIG(TRIG_RISE)) dutRise (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRe(busRe), .busRdata(rdata[1]), .pinIn(pinIn), .pinOut(pOut[1]),
    .pinOe(pOe[1]), .irq(irqV[1]));
  pio_edge_bank #(.PIN_REQ(20), .TRIG(TRIG_FALL)) dutFall (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRe(busRe), .busRdata(rdata[2]), .pinIn(pinIn), .pinOut(pOut[2]),
    .pinOe(pOe[2]), .irq(irqV[2]));
  pio_edge_bank #(.PIN_REQ(8), .TRIG(TRIG_LEVEL)) dutLvl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRe(busRe), .busRdata(rdata[3]), .pinIn(pinIn), .pinOut(pOut[3]),
    .pinOe(pOe[3]), .irq(irqV[3]));

  // bench model: live count and trigger (0 rise, 1 fall, 2 both, 3 level)
  int          nLive [4] = '{32, 12, 20, 8};
  int          trigK [4] = '{2, 0, 1, 3};
  logic [31:0] mOut [4], mDir [4], mMask [4], mCap [4];
  logic [31:0] pins = '0;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  function automatic logic [31:0] liveOf(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] edgesOf(logic [31:0] o, logic [31:0] n, int t);
    case (t)
      0: return n & ~o;
      1: return o & ~n;
      2: return o ^ n;
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] levelOf(int k);
    return ((mDir[k] & mOut[k]) | (~mDir[k] & pins)) & liveOf(nLive[k]);
  endfunction

  function automatic logic irqOf(int k);
    if (trigK[k] == 3) return |(levelOf(k) & mMask[k]);
    return |(mCap[k] & mMask[k]);
  endfunction

  task automatic chk(string tag, int k, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s bank%0d actual=%h expected=%h", tag, k, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic modelWrite(logic [3:0] a, logic [31:0] d);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] v;
      v = d & liveOf(nLive[k]);
      if (a[1:0] == 2'b00) begin
        case (a[3:2])
          2'd0: mOut[k] = v;
          2'd1: mDir[k] = v;
          2'd2: mMask[k] = v;
          default: if (trigK[k] != 3) mCap[k] = mCap[k] & ~v;
        endcase
      end
    end
  endtask

  task automatic regWrite(logic [3:0] a, logic [31:0] d);
    busWrite(a, d);
    modelWrite(a, d);
  endtask

  task automatic busRead(logic [3:0] a);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic setPins(logic [31:0] n);
    logic [31:0] o;
    o = pins;
    @(negedge clk);
    pinIn = n; pins = n;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++)
      mCap[k] |= edgesOf(o, n, trigK[k]) & liveOf(nLive[k]);
  endtask

  // edge and clearing write land on the same clock
  task automatic collide(logic [31:0] n, logic [31:0] w);
    logic [31:0] o;
    o = pins;
    @(negedge clk);
    pinIn = n; pins = n;
    @(negedge clk);
    busWrite(4'hC, w);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++)
      if (trigK[k] != 3)
        mCap[k] = (mCap[k] & ~(w & liveOf(nLive[k]))) | (edgesOf(o, n, trigK[k]) & liveOf(nLive[k]));
  endtask

  task automatic checkAll(string tag);
    busRead(4'h0);
    for (int k = 0; k < 4; k++) chk({tag, " R4 data"}, k, rdata[k], levelOf(k));
    busRead(4'h4);
    for (int k = 0; k < 4; k++) chk({tag, " R1 dir"}, k, rdata[k], mDir[k]);
    busRead(4'h8);
    for (int k = 0; k < 4; k++) chk({tag, " R6 mask"}, k, rdata[k], mMask[k]);
    busRead(4'hC);
    for (int k = 0; k < 4; k++) chk({tag, " R7 R11 cap"}, k, rdata[k], mCap[k]);
    for (int k = 0; k < 4; k++) begin
      chk({tag, " R3 out"}, k, pOut[k], mOut[k]);
      chk({tag, " R3 R2 oe"}, k, pOe[k], mDir[k]);
      chk({tag, " R8 R11 irq"}, k, 32'(irqV[k]), 32'(irqOf(k)));
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    for (int k = 0; k < 4; k++) begin
      mOut[k] = '0; mDir[k] = '0; mMask[k] = '0; mCap[k] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R5: everything reads zero after reset
    checkAll("R5 reset");

    // R2: writes to dead bits are dropped, clamp to 32 keeps bit 31
    regWrite(4'h0, 32'hFFFF_FFFF);
    regWrite(4'h4, 32'hFFFF_FFFF);
    checkAll("R2 clamp");

    // R1: misaligned access changes nothing and reads zero
    busWrite(4'h5, 32'h0);
    busRead(4'h5);
    for (int k = 0; k < 4; k++) chk("R1 misaligned read", k, rdata[k], 32'h0);
    checkAll("R1 misaligned write");

    // R7 R8: edge capture into inputs, interrupt enabled
    regWrite(4'h4, 32'h0);
    regWrite(4'h8, 32'hFFFF_FFFF);
    setPins(32'h0000_00F1);
    checkAll("R7 rise");
    setPins(32'h0000_0001);
    checkAll("R7 fall");

    // R9: clear selected bits
    regWrite(4'hC, 32'h0000_00F0);
    checkAll("R9 w1c partial");
    regWrite(4'hC, 32'hFFFF_FFFF);
    checkAll("R9 w1c all");

    // R10: edge on bit 1 while the same bit is cleared
    setPins(32'h0000_0003);
    checkAll("R10 setup");
    collide(32'h0000_0001, 32'h0000_0002);
    checkAll("R10 collide");

    // R6: enable off blocks irq while capture stays held
    regWrite(4'h8, 32'h0);
    checkAll("R6 masked");

    // random mix
    for (int i = 0; i < 60; i++) begin
      int op;
      op = $urandom % 6;
      case (op)
        0: regWrite(4'h0, $urandom);
        1: regWrite(4'h4, $urandom);
        2: regWrite(4'h8, $urandom);
        3: regWrite(4'hC, $urandom);
        4: collide($urandom, $urandom);
        default: setPins($urandom);
      endcase
      checkAll("rand");
    end

    finishRun();
  end
endmodule